// File: doc/BRIEF.md
# Low-Power Mode Control Register with CPU Access Stall

This block is the software-visible control byte of a small controller's power manager. A single write can ask for one of two low-power states: a light sleep, or a deeper watch/stop state. The same write can also fire a short internal reset pulse, choose whether the chip's pins float while the deep state lasts, and pick the length of a CPU clock stall. The two request outputs go to the oscillator sequencer, which acknowledges wake-up on a release input. That release, or any reset, withdraws the outstanding request.

The second job is throttling the CPU. Each time the CPU begins a bus access, the block drops the CPU clock enable for 0, 9, 17 or 33 cycles, as the stall field selects. Peripheral clocks keep running. If a second access is requested while a stall is under way, it is queued and starts its own stall as soon as the first one ends. The stall field survives warm resets. Only a cold reset clears it; cold resets are power-on, hardware standby and watchdog.

Top module: `lpm_ctrl`

## Requirements
- R1: A write with bit 6 = 1 and bit 7 = 0 sets sleep_req from the next cycle and clears stop_req. A write with bit 6 = 0 and bit 7 = 0 leaves both requests as they were.
- R2: A write with bit 7 = 1 sets stop_req from the next cycle, whatever bit 6 holds, and clears sleep_req.
- R3: mode_release clears sleep_req and stop_req in the next cycle, and it wins over a request written in the same cycle. rst or cold_rst also clears both.
- R4: Bit 5 is stored by every write and drives pin_hiz (1 = pins float in watch/stop). It reads back at bit 5, and either reset clears it.
- R5: A write with bit 4 = 0 raises soft_rst for exactly 3 cycles, starting with the next cycle. A new such write restarts the 3-cycle count. A write with bit 4 = 1 has no effect on soft_rst.
- R6: Bits 2:1 select the stall length: 00 = 0, 01 = 9, 10 = 17, 11 = 33 cycles. A bus_req while idle drives cpu_clk_en low for that many cycles, starting in the next cycle. The value used is the field held before any write in the same cycle.
- R7: A bus_req that arrives while a stall is running is held. Its stall starts right after the current one, with no cpu_clk_en high cycle between them.
- R8: cold_rst clears bits 2:1. rst alone leaves them unchanged, and a write during rst is ignored.
- R9: On reads, bits 7 and 6 give 0, bits 4 and 3 give 1 and bit 0 gives 0, whatever was written. The reset value of rd_data is 8'h18.
- R10: sleep_req and stop_req are never both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous warm reset, active high; keeps the stall field |
| cold_rst | input | 1 | Synchronous cold reset (power-on, standby, watchdog), active high |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register read value |
| mode_release | input | 1 | Sleep or stop state has been left |
| bus_req | input | 1 | CPU starts a bus access |
| sleep_req | output | 1 | Sleep mode request |
| stop_req | output | 1 | Watch/stop mode request |
| pin_hiz | output | 1 | Pins go high impedance in watch/stop |
| soft_rst | output | 1 | Software-generated internal reset pulse |
| cpu_clk_en | output | 1 | CPU clock enable, low during a stall |

## Verification
The stall path is exercised first with a single isolated access for each of the four field values, which separates the lengths from one another. It is then driven with a second access during a stall, and with a second access on the final stall cycle. Those two cases show whether queued stalls are joined back to back or lost. Command writes cover sleep alone, stop alone, both bits together, a stop that replaces a sleep, and release arriving with a write. These patterns separate the bit priorities. Warm and cold resets with a non-zero stall field show which reset cause clears it.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

  localparam int unsigned REG_W = 8;

  // Register bit positions: decoded by software, so fixed.
  localparam int unsigned B_STOP  = 7;
  localparam int unsigned B_SLEEP = 6;
  localparam int unsigned B_HIZ   = 5;
  localparam int unsigned B_SRSTN = 4;
  localparam int unsigned B_RSV1  = 3;
  localparam int unsigned B_CGHI  = 2;
  localparam int unsigned B_CGLO  = 1;
  localparam int unsigned B_RSV0  = 0;

  typedef enum logic [1:0] {
    MODE_RUN   = 2'b00,
    MODE_SLEEP = 2'b01,
    MODE_STOP  = 2'b10
  } lp_mode_e;

  // Stall length: 0, or unit * 2^(sel-1) + 1 cycles.
  function automatic int unsigned stall_len(input logic [1:0] sel,
                                            input int unsigned unit);
    int unsigned n;
    if (sel == 2'b00) n = 0;
    else n = (unit << (sel - 2'd1)) + 1;
    return n;
  endfunction

endpackage

// File: rtl/lpm_cmd_reg.sv
module lpm_cmd_reg
  import lpm_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             cold_rst,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             mode_release,
  output logic             sleep_req,
  output logic             stop_req,
  output logic             pin_hiz,
  output logic [1:0]       stall_sel,
  output logic [REG_W-1:0] rd_data
);

  lp_mode_e mode_q;
  logic     hiz_q;
  logic [1:0] sel_q;
  logic     any_rst;

  assign any_rst = rst | cold_rst;

  always_ff @(posedge clk) begin
    if (any_rst) begin
      mode_q <= MODE_RUN;
      hiz_q  <= 1'b0;
    end else begin
      if (wr_en) begin
        hiz_q <= wr_data[B_HIZ];
        if (wr_data[B_STOP])       mode_q <= MODE_STOP;
        else if (wr_data[B_SLEEP]) mode_q <= MODE_SLEEP;
      end
      if (mode_release) mode_q <= MODE_RUN;
    end
  end

  // Stall field has its own reset domain: only cold causes clear it.
  always_ff @(posedge clk) begin
    if (cold_rst)             sel_q <= 2'b00;
    else if (!rst && wr_en)   sel_q <= wr_data[B_CGHI:B_CGLO];
  end

  assign sleep_req = (mode_q == MODE_SLEEP);
  assign stop_req  = (mode_q == MODE_STOP);
  assign pin_hiz   = hiz_q;
  assign stall_sel = sel_q;

  always_comb begin
    rd_data                 = '0;
    rd_data[B_HIZ]          = hiz_q;
    rd_data[B_SRSTN]        = 1'b1;
    rd_data[B_RSV1]         = 1'b1;
    rd_data[B_CGHI:B_CGLO]  = sel_q;
  end

endmodule

// File: rtl/lpm_srst_pulse.sv
module lpm_srst_pulse #(
  parameter int unsigned PULSE = 3
) (
  input  logic clk,
  input  logic clr,
  input  logic trig,
  output logic pulse
);

  localparam int unsigned CW = $clog2(PULSE + 1);

  logic [CW-1:0] left_q;

  always_ff @(posedge clk) begin
    if (clr)                    left_q <= '0;
    else if (trig)              left_q <= CW'(PULSE);
    else if (left_q != '0)      left_q <= left_q - 1'b1;
  end

  assign pulse = (left_q != '0);

endmodule

// File: rtl/lpm_stall_gen.sv
module lpm_stall_gen
  import lpm_pkg::*;
#(
  parameter int unsigned UNIT  = 8,
  parameter int unsigned CNT_W = 6
) (
  input  logic       clk,
  input  logic       clr,
  input  logic       bus_req,
  input  logic [1:0] sel,
  output logic       cpu_clk_en
);

  logic [CNT_W-1:0] left_q;
  logic             pend_q;
  logic [CNT_W-1:0] load_val;
  logic             start;

  assign load_val = CNT_W'(stall_len(sel, UNIT));
  assign start    = bus_req | pend_q;

  always_ff @(posedge clk) begin
    if (clr) begin
      left_q <= '0;
      pend_q <= 1'b0;
    end else if (left_q <= CNT_W'(1)) begin
      // idle or last stall cycle: a waiting or new access starts now
      if (start) begin
        left_q <= load_val;
        pend_q <= 1'b0;
      end else begin
        left_q <= '0;
      end
    end else begin
      left_q <= left_q - 1'b1;
      if (bus_req) pend_q <= 1'b1;
    end
  end

  assign cpu_clk_en = (left_q == '0);

endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
  import lpm_pkg::*;
#(
  parameter int unsigned STALL_UNIT  = 8,
  parameter int unsigned SRST_CYCLES = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cold_rst,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  input  logic             mode_release,
  input  logic             bus_req,
  output logic             sleep_req,
  output logic             stop_req,
  output logic             pin_hiz,
  output logic             soft_rst,
  output logic             cpu_clk_en
);

  localparam int unsigned STALL_MAX = 4 * STALL_UNIT + 1;
  localparam int unsigned CNT_W     = $clog2(STALL_MAX + 1);

  logic       any_rst;
  logic [1:0] stall_sel;
  logic       srst_trig;

  assign any_rst   = rst | cold_rst;
  assign srst_trig = wr_en & ~wr_data[B_SRSTN];

  lpm_cmd_reg u_cmd (
    .clk          (clk),
    .rst          (rst),
    .cold_rst     (cold_rst),
    .wr_en        (wr_en),
    .wr_data      (wr_data),
    .mode_release (mode_release),
    .sleep_req    (sleep_req),
    .stop_req     (stop_req),
    .pin_hiz      (pin_hiz),
    .stall_sel    (stall_sel),
    .rd_data      (rd_data)
  );

  lpm_srst_pulse #(.PULSE(SRST_CYCLES)) u_srst (
    .clk   (clk),
    .clr   (any_rst),
    .trig  (srst_trig),
    .pulse (soft_rst)
  );

  lpm_stall_gen #(.UNIT(STALL_UNIT), .CNT_W(CNT_W)) u_stall (
    .clk        (clk),
    .clr        (any_rst),
    .bus_req    (bus_req),
    .sel        (stall_sel),
    .cpu_clk_en (cpu_clk_en)
  );

endmodule

// File: rtl/lpm_ctrl_chk.sv
module lpm_ctrl_chk #(
  parameter int unsigned SRST_CYCLES = 3
) (
  input logic       clk,
  input logic       rst,
  input logic       cold_rst,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic [7:0] rd_data,
  input logic       mode_release,
  input logic       bus_req,
  input logic       sleep_req,
  input logic       stop_req,
  input logic       soft_rst,
  input logic       cpu_clk_en
);

  // cycles since the last soft-reset trigger, saturating past the window
  logic [7:0] age_q;
  always_ff @(posedge clk) begin
    if (rst || cold_rst)                 age_q <= '0;
    else if (wr_en && !wr_data[4])       age_q <= 8'd1;
    else if (age_q != '0 && age_q <= 8'(SRST_CYCLES)) age_q <= age_q + 8'd1;
  end

  p_one_mode_r10: assert property (@(posedge clk) disable iff (rst || cold_rst)
    $onehot0({sleep_req, stop_req}));

  p_release_r3: assert property (@(posedge clk) disable iff (rst || cold_rst)
    mode_release |=> (!sleep_req && !stop_req));

  p_fixed_bits_r9: assert property (@(posedge clk) disable iff (rst || cold_rst)
    (rd_data[7:6] == 2'b00) && rd_data[4] && rd_data[3] && !rd_data[0]);

  p_srst_start_r5: assert property (@(posedge clk) disable iff (rst || cold_rst)
    (wr_en && !wr_data[4]) |=> soft_rst);

  p_srst_len_r5: assert property (@(posedge clk) disable iff (rst || cold_rst)
    soft_rst == (age_q != '0 && age_q <= 8'(SRST_CYCLES)));

  p_warm_keep_r8: assert property (@(posedge clk) disable iff (cold_rst)
    rst |=> (rd_data[2:1] == $past(rd_data[2:1])));

  p_no_stall_r6: assert property (@(posedge clk) disable iff (rst || cold_rst)
    (bus_req && cpu_clk_en && rd_data[2:1] == 2'b00) |=> cpu_clk_en);

  p_stall_start_r6: assert property (@(posedge clk) disable iff (rst || cold_rst)
    (bus_req && cpu_clk_en && rd_data[2:1] != 2'b00) |=> !cpu_clk_en);

endmodule

bind lpm_ctrl lpm_ctrl_chk #(.SRST_CYCLES(SRST_CYCLES)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .cold_rst     (cold_rst),
  .wr_en        (wr_en),
  .wr_data      (wr_data),
  .rd_data      (rd_data),
  .mode_release (mode_release),
  .bus_req      (bus_req),
  .sleep_req    (sleep_req),
  .stop_req     (stop_req),
  .soft_rst     (soft_rst),
  .cpu_clk_en   (cpu_clk_en)
);

// File: tb/lpm_ctrl_bench.sv
module lpm_ctrl_bench;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cold_rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       mode_release = 1'b0;
  logic       bus_req = 1'b0;
  logic [7:0] rd_data;
  logic       sleep_req, stop_req, pin_hiz, soft_rst, cpu_clk_en;

  int n_checks = 0;
  int n_errors = 0;
  bit started  = 0;
  bit done     = 0;

  // reference model state
  bit m_sleep, m_stop, m_hiz;
  bit [1:0] m_cg;
  int m_srst_left, m_stall_left;
  bit m_pend;

  always #(CLK_PERIOD/2) clk = ~clk;

  lpm_ctrl u_lpm_ctrl (
    .clk(clk), .rst(rst), .cold_rst(cold_rst), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .mode_release(mode_release), .bus_req(bus_req),
    .sleep_req(sleep_req), .stop_req(stop_req), .pin_hiz(pin_hiz),
    .soft_rst(soft_rst), .cpu_clk_en(cpu_clk_en)
  );

  function automatic int len_of(bit [1:0] s);
    case (s)
      2'd0: return 0;
      2'd1: return 9;
      2'd2: return 17;
      default: return 33;
    endcase
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    int len;
    started = 1;
    if (rst || cold_rst) begin
      m_sleep = 0; m_stop = 0; m_hiz = 0;
      m_srst_left = 0; m_stall_left = 0; m_pend = 0;
      if (cold_rst) m_cg = 0;
    end else begin
      len = len_of(m_cg);
      if (m_stall_left > 1) begin
        m_stall_left--;
        if (bus_req) m_pend = 1;
      end else if (bus_req || m_pend) begin
        m_stall_left = len;
        m_pend = 0;
      end else begin
        m_stall_left = 0;
      end
      if (wr_en && !wr_data[4]) m_srst_left = 3;
      else if (m_srst_left > 0) m_srst_left--;
      if (wr_en) begin
        m_hiz = wr_data[5];
        m_cg  = wr_data[2:1];
        if (wr_data[7]) begin m_stop = 1; m_sleep = 0; end
        else if (wr_data[6]) begin m_sleep = 1; m_stop = 0; end
      end
      if (mode_release) begin m_sleep = 0; m_stop = 0; end
    end
  end

  always @(negedge clk) begin
    if (started && !done) begin
      chk("R1 sleep_req", sleep_req, m_sleep);
      chk("R2 stop_req", stop_req, m_stop);
      chk("R4 pin_hiz", pin_hiz, m_hiz);
      chk("R5 soft_rst", soft_rst, m_srst_left > 0);
      chk("R6 cpu_clk_en", cpu_clk_en, m_stall_left == 0);
      chk("R8 stall field", rd_data[2:1], m_cg);
      chk("R9 read value", rd_data, {2'b00, m_hiz, 2'b11, m_cg, 1'b0});
      chk("R10 one mode", sleep_req && stop_req, 0);
    end
  end

  task automatic write(bit [7:0] d);
    @(negedge clk); wr_en = 1; wr_data = d;
    @(negedge clk); wr_en = 0; wr_data = 8'h00;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // pulse bus_req and count CPU-clock-low cycles
  task automatic measure(int second_at, output int lows);
    int n;
    @(negedge clk); bus_req = 1;
    @(negedge clk); bus_req = 0;
    n = 0;
    while (!cpu_clk_en && n < 200) begin
      n++;
      if (second_at > 0 && n == second_at) bus_req = 1;
      @(negedge clk);
      bus_req = 0;
    end
    lows = n;
  endtask

  initial begin
    int lows;
    idle(3);
    chk("R9 reset read value", rd_data, 8'h18);
    chk("R6 reset clock enable", cpu_clk_en, 1);
    @(negedge clk); rst = 0; cold_rst = 0;

    // R6 each stall length
    for (int s = 0; s < 4; s++) begin
      write(8'h18 | 8'(s << 1));
      measure(0, lows);
      chk("R6 stall length", lows, len_of(2'(s)));
    end

    // R7 queued access mid-stall and on last cycle
    write(8'h1A);
    measure(3, lows);
    chk("R7 queued mid stall", lows, 18);
    measure(9, lows);
    chk("R7 queued on last cycle", lows, 18);
    idle(2);

    // R1 R2 R3 R10 commands
    write(8'h58); chk("R1 sleep set", sleep_req, 1);
    write(8'h18); chk("R1 zero write keeps sleep", sleep_req, 1);
    write(8'h98); chk("R2 stop replaces sleep", stop_req, 1);
    chk("R10 sleep dropped", sleep_req, 0);
    @(negedge clk); mode_release = 1;
    @(negedge clk); mode_release = 0;
    chk("R3 release clears", stop_req, 0);
    @(negedge clk); wr_en = 1; wr_data = 8'hD8; mode_release = 1;
    @(negedge clk); wr_en = 0; mode_release = 0;
    chk("R3 release beats write", stop_req | sleep_req, 0);
    write(8'hD8); chk("R2 both bits give stop", stop_req, 1);

    // R9 reserved bits written opposite, R4 hiz
    write(8'hF7);
    chk("R9 fixed bits ignore write", rd_data, 8'h3E);
    chk("R4 hiz set", pin_hiz, 1);

    // R5 soft reset pulse and retrigger
    write(8'h08); idle(1);
    write(8'h08); idle(6);
    chk("R5 pulse over", soft_rst, 0);

    // R8 warm reset keeps field, write during warm reset ignored
    write(8'h3C);
    @(negedge clk); rst = 1; wr_en = 1; wr_data = 8'h18;
    @(negedge clk); wr_en = 0;
    @(negedge clk); rst = 0;
    chk("R8 warm reset keeps field", rd_data[2:1], 2'b10);
    chk("R4 warm reset clears hiz", pin_hiz, 0);
    measure(0, lows);
    chk("R6 stall after warm reset", lows, 17);
    @(negedge clk); cold_rst = 1;
    @(negedge clk); cold_rst = 0;
    chk("R8 cold reset clears field", rd_data, 8'h18);
    idle(3);

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      done = 1;
      n_errors++; n_checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", WATCHDOG, 0);
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

endmodule